// File: doc/BRIEF.md
# Write-Completion Status Read Logic

This block sits on the read path of a byte-wide nonvolatile memory model. Its job is to choose what a host read returns while an internal programming cycle may be running. When the array is idle, a read returns the stored byte at the current address. When the array is busy, a read returns a status word instead. The top bit of that word is the inverse of the top bit of the last byte written. The next bit down changes value on every new read access. The remaining low bits are copied from the last written byte. A host can poll either bit until the true data comes back, and it can start polling at any point during the write.

A read access is active while chip select and output enable are both low and write enable is high. The block detects the start of each access in the system clock domain. A new access can be started by releasing and reasserting output enable, chip select, or both. The data bus is split into a data output and a drive-enable output; there is no tristate pin. The output is registered, so the value for an access is present on the clock after the strobe goes active. Read strobes are plain control pins: every access is accepted in the cycle it arrives, and the block never applies back-pressure.

Top module: `wcs_status_read`

## Requirements
- R1: After reset, `rd_drive` is 0 and `rd_data` is all zeros.
- R2: `rd_drive` is 1 in the cycle after a cycle in which `cs_n`=0, `oe_n`=0 and `we_n`=1, and 0 after any other input combination. While `rd_drive` is 0, `rd_data` is all zeros and does not change with `mem_data` or `last_wr`.
- R3: With `prog_busy`=0, a read returns `mem_data` sampled on the previous clock, on all bits.
- R4: With `prog_busy`=1, bit DATA_W-1 (bit 7 by default) of a read is the inverse of bit DATA_W-1 of `last_wr`.
- R5: With `prog_busy`=1, bits DATA_W-3 down to 0 of a read equal the same bits of `last_wr`.
- R6: With `prog_busy` held at 1, bit DATA_W-2 (bit 6 by default) takes the opposite value on each new read access. This holds whether the access is restarted through `oe_n`, `cs_n` or both.
- R7: Within one continuous busy read access, bit DATA_W-2 keeps its value from cycle to cycle.
- R8: Once `prog_busy` returns to 0, successive reads return true `mem_data` on every bit, and bit DATA_W-2 stops alternating.
- R9: The first read access that starts after `prog_busy` rises reports bit DATA_W-2 equal to parameter TOG_INIT. This holds even when that access starts in the same cycle as the rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low; a read requires it high |
| prog_busy | input | 1 | High while an internal programming cycle runs |
| last_wr | input | DATA_W | Last byte loaded by the host |
| mem_data | input | DATA_W | Stored array byte at the current address |
| rd_data | output | DATA_W | Registered read data |
| rd_drive | output | 1 | High when `rd_data` would be driven onto the bus |

## Verification
The hardest behaviour to reach is the bit-6 alternation. Every read inside one busy window advances it, so its expected value depends on the whole history of accesses since the busy flag rose.

The bench holds `prog_busy` high for a full sweep of all 256 `last_wr` values. It restarts each access by rotating through the three ways of doing so (output enable only, chip select only, both). It keeps its own running expected toggle value, which it reloads with TOG_INIT each time the busy flag rises.

Some accesses are held for several cycles to exercise R7. One busy window is opened in the same cycle as an access starts, which exercises the restart case of R9.

// File: rtl/wcs_pkg.sv
package wcs_pkg;
  typedef enum logic [1:0] {
    SRC_QUIET  = 2'd0,
    SRC_ARRAY  = 2'd1,
    SRC_STATUS = 2'd2
  } rd_src_e;
endpackage

// File: rtl/wcs_strobe_detect.sv
module wcs_strobe_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic oe_n,
  input  logic we_n,
  output logic rd_active,
  output logic rd_start
);
  logic act_q;

  assign rd_active = !cs_n && !oe_n && we_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= 1'b0;
    else        act_q <= rd_active;
  end

  // a new access begins when the combined strobe turns active
  assign rd_start = rd_active && !act_q;
endmodule

// File: rtl/wcs_toggle_track.sv
module wcs_toggle_track #(
  parameter logic TOG_INIT = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic rd_start,
  output logic tog_rep
);
  logic busy_q;
  logic nxt_q;   // value the next access will report
  logic cur_q;   // value reported by the access in progress
  logic busy_start;
  logic base;
  logic advance;

  assign busy_start = busy && !busy_q;
  assign base       = busy_start ? TOG_INIT : nxt_q;
  assign advance    = rd_start && busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      nxt_q  <= TOG_INIT;
      cur_q  <= TOG_INIT;
    end else begin
      busy_q <= busy;
      if (advance) begin
        cur_q <= base;
        nxt_q <= ~base;
      end else begin
        nxt_q <= base;
      end
    end
  end

  assign tog_rep = advance ? base : cur_q;
endmodule

// File: rtl/wcs_out_mux.sv
module wcs_out_mux
  import wcs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rd_src_e           src,
  input  logic [DATA_W-1:0] last_wr,
  input  logic [DATA_W-1:0] mem_data,
  input  logic              tog_rep,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_drive
);
  localparam int POLL_IDX = DATA_W - 1;
  localparam int TOG_IDX  = DATA_W - 2;

  logic [DATA_W-1:0] status_word;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (i == POLL_IDX) begin : g_poll
      assign status_word[i] = ~last_wr[i];
    end else if (i == TOG_IDX) begin : g_tog
      assign status_word[i] = tog_rep;
    end else begin : g_copy
      assign status_word[i] = last_wr[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_drive <= 1'b0;
    end else begin
      unique case (src)
        SRC_ARRAY: begin
          rd_data  <= mem_data;
          rd_drive <= 1'b1;
        end
        SRC_STATUS: begin
          rd_data  <= status_word;
          rd_drive <= 1'b1;
        end
        default: begin
          rd_data  <= '0;
          rd_drive <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/wcs_status_read.sv
module wcs_status_read
  import wcs_pkg::*;
#(
  parameter int   DATA_W   = 8,
  parameter logic TOG_INIT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              prog_busy,
  input  logic [DATA_W-1:0] last_wr,
  input  logic [DATA_W-1:0] mem_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_drive
);
  logic    rd_active;
  logic    rd_start;
  logic    tog_rep;
  rd_src_e src;

  wcs_strobe_detect u_strobe (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .oe_n      (oe_n),
    .we_n      (we_n),
    .rd_active (rd_active),
    .rd_start  (rd_start)
  );

  wcs_toggle_track #(.TOG_INIT(TOG_INIT)) u_tog (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (prog_busy),
    .rd_start (rd_start),
    .tog_rep  (tog_rep)
  );

  always_comb begin
    if (!rd_active)     src = SRC_QUIET;
    else if (prog_busy) src = SRC_STATUS;
    else                src = SRC_ARRAY;
  end

  wcs_out_mux #(.DATA_W(DATA_W)) u_mux (
    .clk      (clk),
    .rst_n    (rst_n),
    .src      (src),
    .last_wr  (last_wr),
    .mem_data (mem_data),
    .tog_rep  (tog_rep),
    .rd_data  (rd_data),
    .rd_drive (rd_drive)
  );
endmodule

// File: rtl/wcs_status_read_chk.sv
module wcs_status_read_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              oe_n,
  input logic              we_n,
  input logic              prog_busy,
  input logic [DATA_W-1:0] last_wr,
  input logic [DATA_W-1:0] mem_data,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_drive
);
  logic strobe;
  logic strobe_q;
  logic busy_q;

  assign strobe = !cs_n && !oe_n && we_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      busy_q   <= 1'b0;
    end else begin
      strobe_q <= strobe;
      busy_q   <= prog_busy;
    end
  end

  assert_drive_on_R2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> rd_drive);
  assert_drive_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> !rd_drive);
  assert_quiet_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_drive |-> rd_data == '0);
  assert_idle_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !prog_busy) |=> rd_data == $past(mem_data));
  assert_poll_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && prog_busy) |=> rd_data[DATA_W-1] == ~$past(last_wr[DATA_W-1]));
  assert_low_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && prog_busy) |=> rd_data[DATA_W-3:0] == $past(last_wr[DATA_W-3:0]));
  assert_tog_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && strobe_q && prog_busy && busy_q) |=> $stable(rd_data[DATA_W-2]));
endmodule

bind wcs_status_read wcs_status_read_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_n      (cs_n),
  .oe_n      (oe_n),
  .we_n      (we_n),
  .prog_busy (prog_busy),
  .last_wr   (last_wr),
  .mem_data  (mem_data),
  .rd_data   (rd_data),
  .rd_drive  (rd_drive)
);

// File: tb/wcs_status_read_tb.sv
module wcs_status_read_tb_top;
  localparam int   DATA_W   = 8;
  localparam logic TOG_INIT = 1'b1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cs_n = 1'b1;
  logic              oe_n = 1'b1;
  logic              we_n = 1'b1;
  logic              prog_busy = 1'b0;
  logic [DATA_W-1:0] last_wr = '0;
  logic [DATA_W-1:0] mem_data = '0;
  logic [DATA_W-1:0] rd_data;
  logic              rd_drive;

  int  total = 0;
  int  bad = 0;
  bit  finished = 0;
  logic exp_tog;

  always #2 clk = ~clk;

  wcs_status_read #(.DATA_W(DATA_W), .TOG_INIT(TOG_INIT)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
    .prog_busy(prog_busy), .last_wr(last_wr), .mem_data(mem_data),
    .rd_data(rd_data), .rd_drive(rd_drive)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] status_of(input logic [DATA_W-1:0] v, input logic t);
    logic [DATA_W-1:0] s;
    s = v;
    s[DATA_W-1] = ~v[DATA_W-1];
    s[DATA_W-2] = t;
    return s;
  endfunction

  // open an access, check the first registered word, then hold and release
  task automatic busy_read(input int mode, input int hold);
    logic [DATA_W-1:0] e;
    cs_n = 1'b0; oe_n = 1'b0;
    @(negedge clk);
    e = status_of(last_wr, exp_tog);
    chk(rd_drive === 1'b1, "R2", 32'(rd_drive), 32'd1);
    chk(rd_data === e, "R4 R5 R6", 32'(rd_data), 32'(e));
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      chk(rd_data[DATA_W-2] === exp_tog, "R7", 32'(rd_data[DATA_W-2]), 32'(exp_tog));
    end
    exp_tog = ~exp_tog;
    case (mode)
      0: oe_n = 1'b1;
      1: cs_n = 1'b1;
      default: begin oe_n = 1'b1; cs_n = 1'b1; end
    endcase
    @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog all requirements actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(rd_drive === 1'b0, "R1", 32'(rd_drive), 32'd0);
    chk(rd_data === '0, "R1", 32'(rd_data), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: all eight strobe combinations
    for (int c = 0; c < 8; c++) begin
      cs_n = c[0]; oe_n = c[1]; we_n = c[2];
      mem_data = 8'(8'h3C + c);
      @(negedge clk);
      chk(rd_drive === (c == 4), "R2", 32'(rd_drive), 32'(c == 4));
      if (c != 4) chk(rd_data === '0, "R2", 32'(rd_data), 32'd0);
      else        chk(rd_data === mem_data, "R2", 32'(rd_data), 32'(mem_data));
    end
    cs_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    @(negedge clk);

    // R3: idle sweep of all array values, one long held access
    cs_n = 1'b0; oe_n = 1'b0;
    for (int v = 0; v < 256; v++) begin
      mem_data = 8'(v);
      @(negedge clk);
      chk(rd_data === 8'(v), "R3", 32'(rd_data), 32'(v));
    end
    cs_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);

    // R9 + R6: busy window opened together with an access
    last_wr = 8'hA5;
    prog_busy = 1'b1;
    exp_tog = TOG_INIT;
    busy_read(2, 0);

    // R4 R5 R6: sweep every last byte with rotating restart modes
    for (int v = 0; v < 256; v++) begin
      last_wr = 8'(v);
      mem_data = 8'(~v);
      busy_read(v % 3, (v % 16 == 0) ? 3 : 0);
    end

    // R2: quiet while busy and inputs move
    mem_data = 8'h11; last_wr = 8'h22;
    @(negedge clk);
    chk(rd_drive === 1'b0 && rd_data === '0, "R2", 32'(rd_data), 32'd0);

    // R8: write finishes, true data and no alternation
    prog_busy = 1'b0;
    mem_data = 8'hC7;
    for (int r = 0; r < 4; r++) begin
      cs_n = 1'b0; oe_n = 1'b0;
      @(negedge clk);
      chk(rd_data === 8'hC7, "R8", 32'(rd_data), 32'hC7);
      oe_n = 1'b1;
      @(negedge clk);
    end
    cs_n = 1'b1;
    @(negedge clk);

    // R9: a later write cycle restarts the toggle sequence
    prog_busy = 1'b1;
    last_wr = 8'h5A;
    @(negedge clk);
    exp_tog = TOG_INIT;
    busy_read(0, 1);
    busy_read(1, 0);
    busy_read(2, 2);
    prog_busy = 1'b0;
    @(negedge clk);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule